// File: doc/BRIEF.md
# Audio Sample Rate-Adapting Buffer

This block sits between a processor that writes 8-bit audio samples and an output stage that consumes 16-bit samples at a higher rate. Each byte the processor writes goes into an eight-entry first-in first-out store. The output side pulses a request strobe once per output sample period. The buffer answers each request with the oldest stored byte in the upper half of a 16-bit word and zeros in the lower half. It presents each stored sample a programmable number of times before it moves to the next one, so a slow input rate can feed a faster output stage.

Three status flags tell the processor how to pace its writes. The request flag asks for more data. It has hysteresis around the half-full point, so the processor can write in bursts. The under-run flag records that the output side has run dry. The busy flag shows that the store is full. The request flag and the under-run flag each have an enable, and the enabled flags are combined into one interrupt line.

Top module: `pcm_rate_buffer`

## Requirements
- R1: Accepted bytes leave the buffer in the order they were written, and the buffer holds at most 8 bytes at once.
- R2: `sample_out` is a register that changes only in the clock edge that samples `rd_req` high. It then carries the head byte in bits 15:8 and 8'h00 in bits 7:0.
- R3: `dup_sel` values 2'b00, 2'b01, 2'b10 and 2'b11 make each stored byte answer 1, 2, 3 and 4 consecutive requests respectively. The byte is removed only after its last repetition.
- R4: `busy` is high exactly while 8 bytes are stored. A write strobed while `busy` is high is discarded and changes neither the contents nor the occupancy.
- R5: `sreq` rises when the occupancy goes from 4 to 3 and falls when it goes from 4 to 5. Every other occupancy change, including one that leaves the count at 4, keeps its value.
- R6: `urun` is set when a request removes the last stored byte or when a request finds the buffer empty. A request on an empty buffer returns 16'h0000.
- R7: Once set, `urun` stays high until `urun_clr` is pulsed or a write is accepted.
- R8: `irq` is high whenever (`sreq` and `req_ie`) or (`urun` and `urun_ie`) is high.
- R9: After reset the buffer is empty, `sample_out` is 16'h0000, `sreq` is 1, and `urun` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Processor byte write strobe |
| wr_byte | input | 8 | Byte to store |
| rd_req | input | 1 | Output-side request for one sample |
| dup_sel | input | 2 | Repeat count select (repeats = value + 1) |
| urun_clr | input | 1 | Clears the under-run flag |
| req_ie | input | 1 | Lets the request flag drive `irq` |
| urun_ie | input | 1 | Lets the under-run flag drive `irq` |
| sample_out | output | 16 | Widened sample, zero low byte |
| sreq | output | 1 | Request flag with half-full hysteresis |
| urun | output | 1 | Sticky under-run flag |
| busy | output | 1 | Buffer full |
| irq | output | 1 | Combined interrupt request |

## Verification
The in-line assertions assume that every input is driven to a known level at each clock edge. They also assume that `dup_sel` stays constant while a sample is partway through its repetitions. The repeat counter treats a field that shrinks below the current count as already at its last repetition, and the properties on removal timing do not cover that case. The stimulus applies every input half a period away from the sampling edge and changes `dup_sel` only when the buffer is empty. Writes and requests are issued in separate cycles, so every occupancy step that the flag properties look at is a single increment or decrement.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

   // Repeat-count encoding of the duplication select field
   typedef enum logic [1:0] {
      REP_ONCE  = 2'b00,
      REP_TWICE = 2'b01,
      REP_THRICE = 2'b10,
      REP_FOUR  = 2'b11
   } rep_e;

   // Number of times a select value presents one sample
   function automatic int unsigned rep_count(input logic [1:0] sel);
      return int'(sel) + 1;
   endfunction

endpackage

// File: rtl/pcm_store.sv
module pcm_store #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          pop,
   output logic [DW-1:0] head_data,
   output logic [CW-1:0] occ,
   output logic          full,
   output logic          empty,
   output logic          push
);

   logic [DW-1:0] slot [DEPTH];
   logic [AW-1:0] wptr, rptr;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pcm_store: DEPTH must be a power of two of at least 2");
   end

   assign full  = (occ == CW'(DEPTH));
   assign empty = (occ == '0);
   assign push  = wr_en && !full;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (push && wptr == AW'(g))
            slot[g] <= wr_data;
      end
   end

   assign head_data = slot[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (push) wptr <= wptr + 1'b1;
         if (pop)  rptr <= rptr + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   // R1: occupancy never exceeds the depth
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(DEPTH));

   // R4: a write into a full store with no removal leaves the count alone
   a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !pop) |=> (full && occ == $past(occ)));

   // R1: no removal from an empty store
   a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

endmodule

// File: rtl/pcm_repeat.sv
module pcm_repeat #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             empty,
   input  logic [SEL_W-1:0] dup_sel,
   output logic             pop
);

   logic [SEL_W-1:0] served;
   logic             last_rep;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("pcm_repeat: SEL_W must lie in 1..4");
   end

   assign last_rep = (served >= dup_sel);
   assign pop      = rd_req && !empty && last_rep;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         served <= '0;
      else if (rd_req && !empty)
         served <= last_rep ? '0 : served + 1'b1;
   end

   // R3: after a removal the next sample starts its count afresh
   a_r3_restart_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (served == '0));

   // R3: a request that does not remove advances the repeat count
   a_r3_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !empty && !pop) |=> (served == $past(served) + 1'b1));

endmodule

// File: rtl/pcm_flags.sv
module pcm_flags #(
   parameter int DEPTH = 8,
   parameter int LEVEL = DEPTH / 2,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] occ,
   input  logic          push,
   input  logic          pop,
   input  logic          rd_req,
   input  logic          empty,
   input  logic          urun_clr,
   output logic          sreq,
   output logic          urun
);

   logic at_level, fall_below, rise_above, drained, starved;

   if (LEVEL < 1 || LEVEL >= DEPTH) begin : g_bad_level
      $error("pcm_flags: LEVEL must lie strictly between 0 and DEPTH");
   end

   assign at_level   = (occ == CW'(LEVEL));
   assign fall_below = at_level && pop && !push;
   assign rise_above = at_level && push && !pop;
   assign drained    = (occ == CW'(1)) && pop && !push;
   assign starved    = rd_req && empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreq <= 1'b1;
      else if (fall_below)
         sreq <= 1'b1;
      else if (rise_above)
         sreq <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         urun <= 1'b0;
      else if ((drained || starved) && !push)
         urun <= 1'b1;
      else if (push || urun_clr)
         urun <= 1'b0;
   end

   // R5: leaving the threshold downward raises the request
   a_r5_request_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (at_level && pop && !push) |=> sreq);

   // R5: leaving the threshold upward drops the request
   a_r5_quiet_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (at_level && push && !pop) |=> !sreq);

   // R5: no change away from the threshold
   a_r5_hold_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      !at_level |=> $stable(sreq));

   // R6: draining the last sample flags an under-run
   a_r6_flag_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == CW'(1) && pop && !push) |=> urun);

   // R7: the flag only falls on a clear or an accepted write
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (urun && !urun_clr && !push) |=> urun);

endmodule

// File: rtl/pcm_rate_buffer.sv
module pcm_rate_buffer #(
   parameter int DEPTH = 8,
   parameter int IN_W  = 8,
   parameter int PAD_W = 8,
   parameter int SEL_W = 2,
   parameter int LEVEL = DEPTH / 2,
   localparam int OUT_W = IN_W + PAD_W,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IN_W-1:0]  wr_byte,
   input  logic             rd_req,
   input  logic [SEL_W-1:0] dup_sel,
   input  logic             urun_clr,
   input  logic             req_ie,
   input  logic             urun_ie,
   output logic [OUT_W-1:0] sample_out,
   output logic             sreq,
   output logic             urun,
   output logic             busy,
   output logic             irq
);

   logic [IN_W-1:0]  head;
   logic [CW-1:0]    occ;
   logic             full, empty, push, pop;
   logic [OUT_W-1:0] widened;

   pcm_store #(.DEPTH(DEPTH), .DW(IN_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_byte),
      .pop(pop), .head_data(head), .occ(occ), .full(full),
      .empty(empty), .push(push)
   );

   pcm_repeat #(.SEL_W(SEL_W)) u_repeat (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .empty(empty),
      .dup_sel(dup_sel), .pop(pop)
   );

   pcm_flags #(.DEPTH(DEPTH), .LEVEL(LEVEL)) u_flags (
      .clk(clk), .rst_n(rst_n), .occ(occ), .push(push), .pop(pop),
      .rd_req(rd_req), .empty(empty), .urun_clr(urun_clr),
      .sreq(sreq), .urun(urun)
   );

   if (PAD_W > 0) begin : g_pad
      assign widened = {head, {PAD_W{1'b0}}};
   end else begin : g_nopad
      assign widened = head;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sample_out <= '0;
      else if (rd_req)
         sample_out <= empty ? '0 : widened;
   end

   assign busy = full;
   assign irq  = (sreq && req_ie) || (urun && urun_ie);

   // R6: an empty buffer answers with silence
   a_r6_empty_silence: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty) |=> (sample_out == '0));

   // R2: output holds between requests
   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(sample_out));

endmodule

// File: tb/sim_pcm_rate_buffer.sv
module sim_pcm_rate_buffer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        wr_en = 0;
   logic [7:0]  wr_byte = 0;
   logic        rd_req = 0;
   logic [1:0]  dup_sel = 0;
   logic        urun_clr = 0;
   logic        req_ie = 0;
   logic        urun_ie = 0;
   logic [15:0] sample_out;
   logic        sreq, urun, busy, irq;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [7:0]  model_q[$];
   int          model_rep = 0;
   logic [15:0] exp_q[$];
   logic        req_seen = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pcm_rate_buffer u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_byte(wr_byte),
      .rd_req(rd_req), .dup_sel(dup_sel), .urun_clr(urun_clr),
      .req_ie(req_ie), .urun_ie(urun_ie), .sample_out(sample_out),
      .sreq(sreq), .urun(urun), .busy(busy), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      wr_en = 1; wr_byte = b;
      if (model_q.size() < 8) model_q.push_back(b);
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic take();
      logic [15:0] e;
      @(negedge clk);
      rd_req = 1;
      if (model_q.size() == 0) e = 16'h0000;
      else begin
         e = {model_q[0], 8'h00};
         if (model_rep == int'(dup_sel)) begin
            void'(model_q.pop_front());
            model_rep = 0;
         end else model_rep++;
      end
      exp_q.push_back(e);
      @(negedge clk);
      rd_req = 0;
   endtask

   // Monitor: note requests at the edge, compare half a period later
   always @(posedge clk) req_seen <= rd_req;
   always @(negedge clk) begin
      if (req_seen && rst_n) begin
         if (exp_q.size() == 0) check("R2 unexpected sample", sample_out, 16'hxxxx);
         else check("R1/R2/R3 sample stream", sample_out, exp_q.pop_front());
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R9 reset state
      check("R9 sample", sample_out, 16'h0000);
      check("R9 sreq", {15'd0, sreq}, 16'd1);
      check("R9 urun", {15'd0, urun}, 16'd0);
      check("R9 busy", {15'd0, busy}, 16'd0);

      // R5: 0->4 keeps request, 4->5 drops it
      for (int i = 0; i < 4; i++) put(8'hA0 + 8'(i));
      check("R5 sreq at 4 after filling", {15'd0, sreq}, 16'd1);
      put(8'hA4);
      check("R5 sreq cleared at 5", {15'd0, sreq}, 16'd0);
      for (int i = 5; i < 8; i++) put(8'hA0 + 8'(i));
      check("R4 busy when full", {15'd0, busy}, 16'd1);
      put(8'hFF);
      check("R4 busy after dropped write", {15'd0, busy}, 16'd1);

      // R1/R2 drain in order, R5 rises on 4->3
      for (int i = 0; i < 4; i++) take();
      check("R4 busy off after reads", {15'd0, busy}, 16'd0);
      check("R5 sreq held at 4", {15'd0, sreq}, 16'd0);
      take();
      check("R5 sreq set at 3", {15'd0, sreq}, 16'd1);
      check("R6 urun not yet", {15'd0, urun}, 16'd0);
      for (int i = 0; i < 3; i++) take();
      check("R6 urun on drain", {15'd0, urun}, 16'd1);
      take();  // empty request returns zero (R6)
      check("R6 urun held after empty request", {15'd0, urun}, 16'd1);

      // R8 interrupt combinations
      urun_ie = 1; @(negedge clk);
      check("R8 irq urun", {15'd0, irq}, 16'd1);
      urun_ie = 0; req_ie = 1; @(negedge clk);
      check("R8 irq sreq", {15'd0, irq}, 16'd1);
      req_ie = 0; @(negedge clk);
      check("R8 irq masked", {15'd0, irq}, 16'd0);

      // R7 clear strobe, then write clears
      urun_clr = 1; @(negedge clk); urun_clr = 0;
      check("R7 urun cleared by strobe", {15'd0, urun}, 16'd0);
      urun_ie = 1; @(negedge clk);
      check("R8 irq low after clear", {15'd0, irq}, 16'd0);
      urun_ie = 0;
      take();
      check("R6 urun on empty request", {15'd0, urun}, 16'd1);
      put(8'h5A);
      check("R7 urun cleared by write", {15'd0, urun}, 16'd0);
      take();
      check("R6 urun after last byte", {15'd0, urun}, 16'd1);

      // R3 repeat counts
      for (int d = 1; d < 4; d++) begin
         dup_sel = 2'(d);
         put(8'hC0 + 8'(d)); put(8'hD0 + 8'(d));
         for (int k = 0; k < 2 * (d + 1); k++) take();
         check("R3 buffer drained after repeats", {15'd0, urun}, 16'd1);
         take();
      end
      dup_sel = 0;

      // R5 hysteresis: 5->4 and 3->4 keep the value
      for (int i = 0; i < 5; i++) put(8'h10 + 8'(i));
      take();
      check("R5 sreq held on 5->4", {15'd0, sreq}, 16'd0);
      put(8'h20);
      check("R5 sreq low at 5", {15'd0, sreq}, 16'd0);
      take(); take();
      check("R5 sreq set on 4->3", {15'd0, sreq}, 16'd1);
      put(8'h21);
      check("R5 sreq held on 3->4", {15'd0, sreq}, 16'd1);
      for (int i = 0; i < 5; i++) take();
      @(negedge clk);
      check("R1 expected queue emptied", 16'(exp_q.size()), 16'd0);
      finish_run();
   end
endmodule